// File: doc/BRIEF.md
# Power-Fail Bus Lockout Controller

This block sits between an asynchronous host bus and a 32-byte register map. The host bus has active-low chip select, read and write strobes, a 5-bit byte address and an 8-bit data bus with a separate output enable. The block passes the strobes through synchronizers and decides whether an access is taking place. It issues one read or write request per host access toward the register map, and it drives the data returned by a read back onto the host bus.

An active-low power-fail input starts the lockout sequence. On its falling edge the block pulses a one-cycle capture strobe so that the present time can be copied into save registers. It then counts slow ticks until the lockout delay has run out. A nonzero delay setting gives the tick count; zero selects the built-in count. The interface then locks, but only at an access boundary. While locked, the host strobes and address have no effect. Read drive stops as soon as power failure is seen, but a write that has already begun runs to its end. When the power-fail input returns high, the lockout is released.

Top module: `pf_lockout_ctrl`

## Requirements
- R1: While chip select and read are both low, `dout_oe` is high and `dout` carries `reg_rdata` for the sampled address. `reg_re` pulses exactly once for each read access.
- R2: Each write access gives exactly one `reg_we` pulse, issued after the strobe ends. It carries the address and the data bus value present while the strobe was low.
- R3: A read or write strobe while chip select is high causes no `reg_re`, no `reg_we` and no bus drive.
- R4: After the synchronized falling edge of `pfail_n`, `lockout` rises once `delay_cfg` ticks have been counted. If `delay_cfg` is 0, the count is 32 ticks. It stays low for one tick fewer than that.
- R5: While `lockout` is high, chip select, read, write and address have no effect: no `reg_re`, no `reg_we`, and `dout_oe` stays low.
- R6: If the lockout delay runs out during a write, the write still completes with its `reg_we`, and `lockout` rises only after that.
- R7: `dout_oe` goes low within four clocks of `pfail_n` going low, even in the middle of a read.
- R8: `capture_stb` is a single one-cycle pulse for each falling edge of `pfail_n`, and never lasts two cycles.
- R9: When `pfail_n` returns high, `lockout` clears within four clocks and the delay count restarts from zero on the next failure.
- R10: Following reset, `lockout`, `dout_oe`, `reg_we`, `reg_re` and `capture_stb` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| rd_n | input | 1 | Host read strobe, active low, asynchronous |
| wr_n | input | 1 | Host write strobe, active low, asynchronous |
| addr | input | 5 | Host byte address |
| din | input | 8 | Host write data |
| dout | output | 8 | Read data toward the host |
| dout_oe | output | 1 | Output enable for `dout` |
| pfail_n | input | 1 | Power-fail indication, active low, asynchronous |
| tick | input | 1 | Slow timing tick, one clock wide |
| delay_cfg | input | 6 | Lockout delay in ticks, 0 selects the built-in count |
| lockout | output | 1 | Host interface is locked |
| capture_stb | output | 1 | One-cycle time snapshot request |
| reg_addr | output | 5 | Register map address |
| reg_wdata | output | 8 | Register map write data |
| reg_we | output | 1 | Register map write pulse |
| reg_re | output | 1 | Register map read pulse |
| reg_rdata | input | 8 | Register map read data for `reg_addr` |

## Verification
A wrong access state shows at the ports within a few clocks of the strobe edge. It appears as a missing or doubled `reg_we`/`reg_re`, or as `dout_oe` high outside a read. A wrong delay count shows as `lockout` rising one tick early or late, so the bench steps ticks one at a time across the boundary. A lost pending-lock flag shows as a write cut short, or as a lockout that never comes once that write has ended.

// File: rtl/pfl_pkg.sv
package pfl_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_LOCK  = 2'd3
  } acc_state_t;
endpackage

// File: rtl/pfl_sync.sv
module pfl_sync #(
  parameter int      W       = 1,
  parameter int      STAGES  = 2,
  parameter logic    RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pfl_lock_timer.sv
module pfl_lock_timer #(
  parameter int CW        = 6,
  parameter int DEF_TICKS = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pf_ok,
  input  logic          tick,
  input  logic [CW-1:0] delay_cfg,
  output logic          pend,
  output logic          capture_stb
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] target;
  logic          pf_prev;

  assign target = (delay_cfg != '0) ? delay_cfg : CW'(DEF_TICKS);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (pf_ok) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (!pend && tick) begin
      cnt <= cnt + 1'b1;
      if (cnt + 1'b1 >= target) pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_prev     <= 1'b1;
      capture_stb <= 1'b0;
    end else begin
      pf_prev     <= pf_ok;
      capture_stb <= pf_prev & ~pf_ok;
    end
  end
endmodule

// File: rtl/pfl_access.sv
module pfl_access
  import pfl_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_act,
  input  logic          wr_act,
  input  logic          pf_ok,
  input  logic          pend,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] reg_rdata,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          reg_re,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          lockout
);
  acc_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ACC_IDLE;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      dout      <= '0;
      dout_oe   <= 1'b0;
    end else begin
      reg_we  <= 1'b0;
      reg_re  <= 1'b0;
      dout_oe <= 1'b0;
      unique case (state)
        ACC_IDLE: begin
          if (pend && !pf_ok) begin
            state <= ACC_LOCK;
          end else if (rd_act) begin
            state    <= ACC_READ;
            reg_addr <= addr;
            reg_re   <= 1'b1;
          end else if (wr_act) begin
            state     <= ACC_WRITE;
            reg_addr  <= addr;
            reg_wdata <= din;
          end
        end
        ACC_READ: begin
          dout    <= reg_rdata;
          dout_oe <= rd_act && pf_ok;
          if (!rd_act) state <= ACC_IDLE;
        end
        ACC_WRITE: begin
          if (wr_act) begin
            reg_wdata <= din;
          end else begin
            reg_we <= 1'b1;
            state  <= ACC_IDLE;
          end
        end
        ACC_LOCK: begin
          if (pf_ok) state <= ACC_IDLE;
        end
        default: state <= ACC_IDLE;
      endcase
    end
  end

  assign lockout = (state == ACC_LOCK);
endmodule

// File: rtl/pf_lockout_ctrl.sv
module pf_lockout_ctrl #(
  parameter int AW        = 5,
  parameter int DW        = 8,
  parameter int CW        = 6,
  parameter int DEF_TICKS = 32,
  parameter int SYNC_LEN  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  input  logic          pfail_n,
  input  logic          tick,
  input  logic [CW-1:0] delay_cfg,
  output logic          lockout,
  output logic          capture_stb,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          reg_re,
  input  logic [DW-1:0] reg_rdata
);
  localparam int NSIG = 4;

  logic [NSIG-1:0] raw_in;
  logic [NSIG-1:0] syn_in;
  logic            cs_s, rd_s, wr_s, pf_ok;
  logic            rd_act, wr_act, pend;

  assign raw_in = {pfail_n, wr_n, rd_n, cs_n};

  pfl_sync #(.W(NSIG), .STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (syn_in)
  );

  assign {pf_ok, wr_s, rd_s, cs_s} = syn_in;
  assign rd_act = ~cs_s & ~rd_s;
  assign wr_act = ~cs_s & ~wr_s;

  pfl_lock_timer #(.CW(CW), .DEF_TICKS(DEF_TICKS)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .pf_ok       (pf_ok),
    .tick        (tick),
    .delay_cfg   (delay_cfg),
    .pend        (pend),
    .capture_stb (capture_stb)
  );

  pfl_access #(.AW(AW), .DW(DW)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .rd_act    (rd_act),
    .wr_act    (wr_act),
    .pf_ok     (pf_ok),
    .pend      (pend),
    .addr      (addr),
    .din       (din),
    .reg_rdata (reg_rdata),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .lockout   (lockout)
  );
endmodule

// File: rtl/pfl_checker.sv
module pfl_checker (
  input logic clk,
  input logic rst,
  input logic pf_ok,
  input logic lockout,
  input logic dout_oe,
  input logic reg_we,
  input logic reg_re,
  input logic capture_stb
);
  p_one_req_r2: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_re));

  p_locked_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    lockout |-> (!reg_re && !reg_we && !dout_oe));

  p_oe_needs_power_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_oe) |-> $past(pf_ok));

  p_lock_after_fail_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(lockout) |-> !$past(pf_ok));

  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    (lockout && pf_ok) |=> !lockout);

  p_cap_single_r8: assert property (@(posedge clk) disable iff (rst)
    capture_stb |=> !capture_stb);
endmodule

bind pf_lockout_ctrl pfl_checker u_pfl_checker (
  .clk         (clk),
  .rst         (rst),
  .pf_ok       (pf_ok),
  .lockout     (lockout),
  .dout_oe     (dout_oe),
  .reg_we      (reg_we),
  .reg_re      (reg_re),
  .capture_stb (capture_stb)
);

// File: tb/test_pf_lockout_ctrl.sv
`timescale 1ns/1ps
module test_pf_lockout_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, pfail_n = 1'b1, tick = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] din = '0;
  logic [5:0] delay_cfg = '0;
  logic [7:0] dout, reg_wdata, reg_rdata;
  logic [4:0] reg_addr;
  logic       dout_oe, lockout, capture_stb, reg_we, reg_re;
  logic [7:0] mem [32];
  int         n_chk = 0, n_bad = 0;
  int         we_cnt = 0, re_cnt = 0, cap_cnt = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  pf_lockout_ctrl i_pf_lockout_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .din(din), .dout(dout), .dout_oe(dout_oe), .pfail_n(pfail_n), .tick(tick),
    .delay_cfg(delay_cfg), .lockout(lockout), .capture_stb(capture_stb),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;
  assign reg_rdata = mem[reg_addr];

  always @(negedge clk) begin
    if (!rst) begin
      if (reg_we) we_cnt++;
      if (reg_re) re_cnt++;
      if (capture_stb) cap_cnt++;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [4:0] a, logic [7:0] d);
    addr = a; din = d; cs_n = 1'b0; wr_n = 1'b0;
    cyc(6);
    wr_n = 1'b1; cs_n = 1'b1;
    cyc(6);
  endtask

  task automatic one_tick();
    tick = 1'b1; cyc(1); tick = 1'b0; cyc(1);
  endtask

  task automatic t_reset();
    cyc(1);
    check("R10 lockout", lockout, 0);
    check("R10 oe", dout_oe, 0);
    check("R10 we/re/cap", {reg_we, reg_re, capture_stb}, 0);
  endtask

  task automatic t_write_read();
    int w0, r0;
    w0 = we_cnt; r0 = re_cnt;
    bus_write(5'd3, 8'hA5);
    bus_write(5'd31, 8'h5C);
    check("R2 we count", we_cnt - w0, 2);
    check("R2 data a3", mem[3], 8'hA5);
    check("R2 data a31", mem[31], 8'h5C);
    addr = 5'd3; cs_n = 1'b0; rd_n = 1'b0;
    cyc(6);
    check("R1 oe", dout_oe, 1);
    check("R1 dout", dout, 8'hA5);
    rd_n = 1'b1; cs_n = 1'b1;
    cyc(6);
    check("R1 oe off", dout_oe, 0);
    check("R1 re count", re_cnt - r0, 1);
  endtask

  task automatic t_no_cs();
    int w0, r0;
    w0 = we_cnt; r0 = re_cnt;
    addr = 5'd3; din = 8'hFF; wr_n = 1'b0; cyc(6); wr_n = 1'b1; cyc(4);
    rd_n = 1'b0; cyc(6);
    check("R3 no oe", dout_oe, 0);
    rd_n = 1'b1; cyc(4);
    check("R3 no req", {we_cnt - w0, re_cnt - r0}, 0);
    check("R3 mem kept", mem[3], 8'hA5);
  endtask

  task automatic t_delay_default();
    int c0, w0, r0;
    c0 = cap_cnt;
    delay_cfg = 6'd0;
    pfail_n = 1'b0; cyc(6);
    check("R8 capture once", cap_cnt - c0, 1);
    for (int i = 0; i < 31; i++) one_tick();
    cyc(6);
    check("R4 default not yet", lockout, 0);
    one_tick(); cyc(4);
    check("R4 default locked", lockout, 1);
    w0 = we_cnt; r0 = re_cnt;
    addr = 5'd7; din = 8'h11; cs_n = 1'b0; wr_n = 1'b0; cyc(6);
    wr_n = 1'b1; rd_n = 1'b0; cyc(6);
    check("R5 no oe", dout_oe, 0);
    rd_n = 1'b1; cs_n = 1'b1; cyc(4);
    check("R5 no req", {we_cnt - w0, re_cnt - r0}, 0);
    pfail_n = 1'b1; cyc(5);
    check("R9 released", lockout, 0);
    check("R8 no capture on rise", cap_cnt - c0, 1);
  endtask

  task automatic t_cfg_and_restart();
    delay_cfg = 6'd3;
    pfail_n = 1'b0; cyc(5);
    one_tick(); one_tick(); cyc(6);
    check("R4 cfg3 after 2", lockout, 0);
    pfail_n = 1'b1; cyc(6);
    pfail_n = 1'b0; cyc(5);
    one_tick(); one_tick(); cyc(6);
    check("R9 count restarted", lockout, 0);
    one_tick(); cyc(4);
    check("R4 cfg3 locked", lockout, 1);
    pfail_n = 1'b1; cyc(6);
  endtask

  task automatic t_write_across();
    int w0;
    w0 = we_cnt;
    delay_cfg = 6'd2;
    addr = 5'd9; din = 8'h3C; cs_n = 1'b0; wr_n = 1'b0; cyc(6);
    pfail_n = 1'b0; cyc(5);
    one_tick(); one_tick(); cyc(6);
    check("R6 held open", lockout, 0);
    wr_n = 1'b1; cs_n = 1'b1; cyc(6);
    check("R6 write done", we_cnt - w0, 1);
    check("R6 data", mem[9], 8'h3C);
    check("R6 locked after", lockout, 1);
    pfail_n = 1'b1; cyc(6);
  endtask

  task automatic t_read_hiz();
    delay_cfg = 6'd20;
    addr = 5'd31; cs_n = 1'b0; rd_n = 1'b0; cyc(6);
    check("R1 oe mid", dout_oe, 1);
    pfail_n = 1'b0; cyc(4);
    check("R7 oe dropped", dout_oe, 0);
    rd_n = 1'b1; cs_n = 1'b1;
    pfail_n = 1'b1; cyc(6);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 8'h00;
    cyc(4); rst = 1'b0;
    t_reset();
    t_write_read();
    t_no_cs();
    t_delay_default();
    t_cfg_and_restart();
    t_write_across();
    t_read_hiz();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule